// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block collects up to 480 interrupt sources, arranged as up to fifteen banks of 32, and delivers each pending source to one of four processor cores at one of three severities: normal, critical or machine check. Each core gets one output line per severity. Hardware sources are caught on their rising edge and held in a per-bank pending word. Software can also raise a source through a set alias of that word, which is how one core interrupts another.

Each source has a 4-bit route nibble. It names the severity in its upper two bits and the core in its lower two. A value with upper bits 00 turns the source off. Each bank also holds one gate word per core and severity. A pending source reaches its core only when its gate bit is set. A summary area after the bank windows lets a core see which banks are driving each of its lines. All storage is reached through a plain 32-bit read/write register port. Read data appears one cycle after the read strobe.

Top module: `intc_router`

## Requirements
- R1: A rising edge on src_i[g*32+k] sets bit (31-k) of bank g's pending word on the next clock edge. A source held high does not set the bit again after software has cleared it.
- R2: A write to bank offset 0x00 replaces the pending word. A read at 0x00 returns it, with reg_rdata_o valid in the cycle after reg_rd_i.
- R3: A read at bank offset 0x04 returns the pending word and clears it in the same cycle.
- R4: A write to bank offset 0x08 clears each pending bit that is written as 1 and leaves the other bits unchanged.
- R5: A write to bank offset 0x0C sets each pending bit that is written as 1. A bit set this way drives the outputs exactly as a hardware edge would.
- R6: When a set (hardware edge or offset 0x0C) and a clear (offset 0x00, 0x04 or 0x08) hit the same bit in the same cycle, the bit ends up set.
- R7: The route nibble for source k sits in the word at bank offset 0x10+4*(k/8), at bits [(7-k%8)*4+3 : (7-k%8)*4]. The word reads back as written.
- R8: A route nibble's upper bits select the severity: 01 normal, 10 critical, 11 machine check. Its lower bits give the core number. Upper bits 00 keep the source away from every output.
- R9: The gate word for core c lives at bank offset 0x20+4c for normal, 0x30+4c for critical and 0x40+4c for machine check. Gate bit (31-k) must be 1 for source k to reach that core's line.
- R10: Summary words start at byte NUM_GROUPS*0x80: normal at +0x00+4c, critical at +0x10+4c, machine check at +0x20+4c. Bit (31-g) is set while bank g drives that line. Each output line is the OR of its summary word.
- R11: After reset every pending, route and gate word is zero and every output line is low. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_GROUPS*32 | Hardware interrupt sources, edge detected |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after reg_rd_i |
| irq_norm_o | output | NUM_CORES | Normal-severity line per core |
| irq_crit_o | output | NUM_CORES | Critical line per core |
| irq_mchk_o | output | NUM_CORES | Machine-check line per core |

## Verification
A hardware edge on a source and a software clear of the same pending bit can land in one clock. In that case the set must win. The bench provokes this by raising the source in the same cycle that it writes the clear alias with that bit. It then judges the result by reading the pending word back through the scoreboard, which must show the bit still set. A second collision comes from the read-to-clear alias meeting an edge. The checker covers it only for the case with no edge, where the word must end at zero.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int SRC_PER_GRP = 32;
   localparam int N_SEV       = 3;

   typedef enum logic [1:0] {
      SEV_OFF    = 2'b00,
      SEV_NORMAL = 2'b01,
      SEV_URGENT = 2'b10,
      SEV_FATAL  = 2'b11
   } sev_e;

   typedef struct packed {
      sev_e       sev;
      logic [1:0] core;
   } route_t;

   // word index inside a bank window (byte offset >> 2)
   localparam logic [4:0] W_PEND     = 5'd0;
   localparam logic [4:0] W_PEND_RC  = 5'd1;
   localparam logic [4:0] W_PEND_CLR = 5'd2;
   localparam logic [4:0] W_PEND_SET = 5'd3;
   localparam logic [4:0] W_ROUTE0   = 5'd4;
   localparam logic [4:0] W_GATE0    = 5'd8;

endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int NUM_CORES = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [SRC_PER_GRP-1:0]         src_i,
   input  logic                           wr_i,
   input  logic                           rd_i,
   input  logic [4:0]                     widx_i,
   input  logic [31:0]                    wdata_i,
   output logic [31:0]                    rdata_o,
   output logic [31:0]                    pend_o,
   output logic [N_SEV*NUM_CORES-1:0]     urge_o
);

   localparam int ROUTE_WORDS = SRC_PER_GRP / 8;

   logic [SRC_PER_GRP-1:0] prev_q;
   logic [31:0]            pend_q, pend_d, rise_msb;
   route_t                 route_q [SRC_PER_GRP];
   logic [31:0]            gate_q  [N_SEV][NUM_CORES];
   logic [31:0]            match   [N_SEV][NUM_CORES];

   // rising edges, mapped so source k lands on bit 31-k
   always_comb begin
      for (int k = 0; k < SRC_PER_GRP; k++)
         rise_msb[31-k] = src_i[k] & ~prev_q[k];
   end

   // clears first, sets last: a set in the same cycle wins
   always_comb begin
      pend_d = pend_q;
      if (wr_i && widx_i == W_PEND)     pend_d = wdata_i;
      if (wr_i && widx_i == W_PEND_CLR) pend_d = pend_d & ~wdata_i;
      if (rd_i && widx_i == W_PEND_RC)  pend_d = '0;
      pend_d = pend_d | rise_msb;
      if (wr_i && widx_i == W_PEND_SET) pend_d = pend_d | wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
         for (int k = 0; k < SRC_PER_GRP; k++) route_q[k] <= '0;
         for (int s = 0; s < N_SEV; s++)
            for (int c = 0; c < NUM_CORES; c++) gate_q[s][c] <= '0;
      end else begin
         prev_q <= src_i;
         pend_q <= pend_d;
         for (int k = 0; k < SRC_PER_GRP; k++)
            if (wr_i && widx_i == W_ROUTE0 + 5'(k / 8))
               route_q[k] <= route_t'(wdata_i[(7 - (k % 8)) * 4 +: 4]);
         for (int s = 0; s < N_SEV; s++)
            for (int c = 0; c < NUM_CORES; c++)
               if (wr_i && widx_i == W_GATE0 + 5'(s * 4 + c))
                  gate_q[s][c] <= wdata_i;
      end
   end

   // per core and severity: which pending bits are routed there
   always_comb begin
      for (int s = 0; s < N_SEV; s++)
         for (int c = 0; c < NUM_CORES; c++)
            for (int k = 0; k < SRC_PER_GRP; k++)
               match[s][c][31-k] = (route_q[k].sev == sev_e'(2'(s + 1))) &&
                                   (route_q[k].core == 2'(c));
   end

   generate
      for (genvar s = 0; s < N_SEV; s++) begin : g_sev
         for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign urge_o[s*NUM_CORES + c] = |(pend_q & gate_q[s][c] & match[s][c]);
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (widx_i <= W_PEND_SET) rdata_o = pend_q;
      for (int w = 0; w < ROUTE_WORDS; w++)
         if (widx_i == W_ROUTE0 + 5'(w))
            for (int j = 0; j < 8; j++)
               rdata_o[(7 - j) * 4 +: 4] = route_q[w*8 + j];
      for (int s = 0; s < N_SEV; s++)
         for (int c = 0; c < NUM_CORES; c++)
            if (widx_i == W_GATE0 + 5'(s * 4 + c)) rdata_o = gate_q[s][c];
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/intc_summary.sv
module intc_summary
   import intc_pkg::*;
#(
   parameter int NUM_GROUPS = 15,
   parameter int NUM_CORES  = 4
) (
   input  logic [NUM_GROUPS*N_SEV*NUM_CORES-1:0] urge_i,
   output logic [N_SEV*NUM_CORES*32-1:0]         sum_o,
   output logic [N_SEV*NUM_CORES-1:0]            irq_o
);

   localparam int LINES = N_SEV * NUM_CORES;

   always_comb begin
      sum_o = '0;
      for (int l = 0; l < LINES; l++)
         for (int g = 0; g < NUM_GROUPS; g++)
            sum_o[l*32 + 31 - g] = urge_i[g*LINES + l];
   end

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_line
         assign irq_o[l] = |sum_o[l*32 +: 32];
      end
   endgenerate

endmodule

// File: rtl/intc_router.sv
module intc_router
   import intc_pkg::*;
#(
   parameter int NUM_GROUPS = 15,
   parameter int NUM_CORES  = 4,
   parameter int ADDR_W     = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_GROUPS*SRC_PER_GRP-1:0]  src_i,
   input  logic                               reg_wr_i,
   input  logic                               reg_rd_i,
   input  logic [ADDR_W-1:0]                  reg_addr_i,
   input  logic [31:0]                        reg_wdata_i,
   output logic [31:0]                        reg_rdata_o,
   output logic [NUM_CORES-1:0]               irq_norm_o,
   output logic [NUM_CORES-1:0]               irq_crit_o,
   output logic [NUM_CORES-1:0]               irq_mchk_o
);

   localparam int GRP_W  = ADDR_W - 7;
   localparam int LINES  = N_SEV * NUM_CORES;

   generate
      if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
         $error("intc_router: NUM_CORES must be 1..4 (2-bit core field)");
      end
      if (NUM_GROUPS < 1 || NUM_GROUPS > 31) begin : g_bad_groups
         $error("intc_router: NUM_GROUPS must be 1..31 (one summary bit each)");
      end
      if (ADDR_W < 8 || NUM_GROUPS >= (1 << (ADDR_W - 7))) begin : g_bad_addr
         $error("intc_router: ADDR_W too small for bank windows plus summary");
      end
   endgenerate

   logic [GRP_W-1:0]                    grp_sel;
   logic [4:0]                          widx;
   logic [31:0]                         bank_rd  [NUM_GROUPS];
   logic [NUM_GROUPS*32-1:0]            stat_all;
   logic [NUM_GROUPS*LINES-1:0]         urge_all;
   logic [LINES*32-1:0]                 sum_flat;
   logic [LINES-1:0]                    irq_all;
   logic [31:0]                         rd_mux;
   logic [31:0]                         rdata_q;
   logic                                unused_addr_lsb;

   assign grp_sel         = reg_addr_i[ADDR_W-1:7];
   assign widx            = reg_addr_i[6:2];
   assign unused_addr_lsb = ^reg_addr_i[1:0];

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
         intc_bank #(.NUM_CORES(NUM_CORES)) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .wr_i    (reg_wr_i && grp_sel == GRP_W'(g)),
            .rd_i    (reg_rd_i && grp_sel == GRP_W'(g)),
            .widx_i  (widx),
            .wdata_i (reg_wdata_i),
            .rdata_o (bank_rd[g]),
            .pend_o  (stat_all[g*32 +: 32]),
            .urge_o  (urge_all[g*LINES +: LINES])
         );
      end
   endgenerate

   intc_summary #(.NUM_GROUPS(NUM_GROUPS), .NUM_CORES(NUM_CORES)) i_summary (
      .urge_i (urge_all),
      .sum_o  (sum_flat),
      .irq_o  (irq_all)
   );

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < NUM_GROUPS; g++)
         if (grp_sel == GRP_W'(g)) rd_mux = bank_rd[g];
      if (grp_sel == GRP_W'(NUM_GROUPS))
         for (int s = 0; s < N_SEV; s++)
            for (int c = 0; c < NUM_CORES; c++)
               if (widx == 5'(s * 4 + c)) rd_mux = sum_flat[(s*NUM_CORES + c)*32 +: 32];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        rdata_q <= '0;
      else if (reg_rd_i) rdata_q <= rd_mux;
   end

   assign reg_rdata_o = rdata_q;
   assign irq_norm_o  = irq_all[0*NUM_CORES +: NUM_CORES];
   assign irq_crit_o  = irq_all[1*NUM_CORES +: NUM_CORES];
   assign irq_mchk_o  = irq_all[2*NUM_CORES +: NUM_CORES];

endmodule

// File: rtl/intc_router_chk.sv
module intc_router_chk #(
   parameter int NUM_GROUPS = 15,
   parameter int NUM_CORES  = 4,
   parameter int ADDR_W     = 12
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [31:0]                    src0,
   input logic                           reg_wr_i,
   input logic                           reg_rd_i,
   input logic [ADDR_W-1:0]              reg_addr_i,
   input logic [31:0]                    reg_wdata_i,
   input logic [31:0]                    reg_rdata_o,
   input logic [NUM_CORES-1:0]           irq_norm_o,
   input logic [NUM_CORES-1:0]           irq_crit_o,
   input logic [NUM_CORES-1:0]           irq_mchk_o,
   input logic [31:0]                    pend0,
   input logic [NUM_GROUPS*3*NUM_CORES-1:0] urge_all
);

   // R11
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_norm_o == '0 && irq_crit_o == '0 && irq_mchk_o == '0));

   // R1
   edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src0[0] && !$past(src0[0])) |=> pend0[31]);

   // R5
   soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_W'('hC) && (reg_wdata_i & 32'h8000_0000) != 0)
      |=> pend0[31]);

   // R4
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_W'('h8) && reg_wdata_i[31] && !src0[0])
      |=> !pend0[31]);

   // R3
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && !reg_wr_i && reg_addr_i == ADDR_W'('h4) && src0 == '0)
      |=> pend0 == '0);

   // R3
   read_clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && reg_addr_i == ADDR_W'('h4)) |=> reg_rdata_o == $past(pend0));

   // R10
   mchk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mchk_o != '0 || irq_crit_o != '0 || irq_norm_o != '0) |-> urge_all != '0);

endmodule

bind intc_router intc_router_chk #(
   .NUM_GROUPS (NUM_GROUPS),
   .NUM_CORES  (NUM_CORES),
   .ADDR_W     (ADDR_W)
) i_intc_router_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src0        (src_i[31:0]),
   .reg_wr_i    (reg_wr_i),
   .reg_rd_i    (reg_rd_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_norm_o  (irq_norm_o),
   .irq_crit_o  (irq_crit_o),
   .irq_mchk_o  (irq_mchk_o),
   .pend0       (stat_all[31:0]),
   .urge_all    (urge_all)
);

// File: tb/test_intc_router.sv
`timescale 1ns/1ps
module test_intc_router;

   localparam int NG = 15;
   localparam int NC = 4;
   localparam int AW = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NG*32-1:0] src = '0;
   logic            reg_wr = 1'b0;
   logic            reg_rd = 1'b0;
   logic [AW-1:0]   reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic [NC-1:0]   irq_norm, irq_crit, irq_mchk;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   always #2 clk = ~clk;

   intc_router #(.NUM_GROUPS(NG), .NUM_CORES(NC), .ADDR_W(AW)) i_intc_router (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src),
      .reg_wr_i    (reg_wr),
      .reg_rd_i    (reg_rd),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_norm_o  (irq_norm),
      .irq_crit_o  (irq_crit),
      .irq_mchk_o  (irq_mchk)
   );

   task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_irq(input logic [NC-1:0] n, input logic [NC-1:0] c,
                            input logic [NC-1:0] m, input string tag);
      check32({20'd0, irq_norm, irq_crit, irq_mchk}, {20'd0, n, c, m}, tag);
   endtask

   task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: the expectation goes into the scoreboard, then the read is issued
   task automatic reg_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // monitor: one read result per strobe seen at the previous edge
   always @(posedge clk) rd_seen <= reg_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual unexpected read %h expected none", reg_rdata);
         end else begin
            check32(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check_irq('0, '0, '0, "R11 outputs after reset");
      reg_read(12'h000, 32'h0, "R11 pending reset");
      reg_read(12'h010, 32'h0, "R11 route reset");
      reg_read(12'h020, 32'h0, "R11 gate reset");
      reg_read(12'h050, 32'h0, "R11 unmapped offset");
      reg_read(12'h788, 32'h0, "R11 summary reset");

      // R7 route source 5 of bank 0 to core 2, normal (nibble 0x6 at bits 11:8)
      reg_write(12'h010, 32'h0000_0600);
      reg_read(12'h010, 32'h0000_0600, "R7 route word readback");
      reg_write(12'h028, 32'h0400_0000);       // R9 normal gate, core 2, bit 26
      check_irq('0, '0, '0, "R8 nothing pending yet");

      // R1 rising edge latches
      src[5] = 1'b1; @(negedge clk);
      reg_read(12'h000, 32'h0400_0000, "R1 edge latched at bit 26");
      check_irq(4'b0100, '0, '0, "R8 normal line of core 2");
      reg_read(12'h788, 32'h8000_0000, "R10 summary bit 31 for bank 0");

      // R4 clear while source held high: no relatch
      reg_write(12'h008, 32'h0400_0000);
      repeat (2) @(negedge clk);
      reg_read(12'h000, 32'h0, "R4 write-one clear / R1 level no relatch");
      check_irq('0, '0, '0, "R4 line drops after clear");
      src[5] = 1'b0; @(negedge clk);

      // R5 software set acts like hardware
      reg_write(12'h00C, 32'h0400_0000);
      check_irq(4'b0100, '0, '0, "R5 software set drives line");
      reg_read(12'h004, 32'h0400_0000, "R3 read-clear returns old value");
      reg_read(12'h000, 32'h0, "R3 pending cleared by read");
      check_irq('0, '0, '0, "R3 line low after read-clear");

      // R9 gate blocks
      reg_write(12'h00C, 32'h0400_0000);
      reg_write(12'h028, 32'h0);
      check_irq('0, '0, '0, "R9 closed gate blocks pending source");
      reg_write(12'h028, 32'h0400_0000);
      check_irq(4'b0100, '0, '0, "R9 reopened gate passes source");

      // R2 plain write and readback
      reg_write(12'h000, 32'hA000_0001);
      reg_read(12'h000, 32'hA000_0001, "R2 plain write readback");
      check_irq('0, '0, '0, "R2 plain write removed bit 26");
      reg_write(12'h000, 32'h0);

      // R6 edge and clear in the same cycle
      src[5] = 1'b1;
      reg_write(12'h008, 32'h0400_0000);
      reg_read(12'h000, 32'h0400_0000, "R6 set wins over clear");
      src[5] = 1'b0;
      reg_write(12'h008, 32'hFFFF_FFFF);
      reg_read(12'h000, 32'h0, "R4 all bits cleared");

      // bank 14, source 31 (input 479): critical to core 3 (nibble 0xB at bits 3:0)
      reg_write(12'h71C, 32'h0000_000B);
      reg_read(12'h71C, 32'h0000_000B, "R7 last nibble of last route word");
      reg_write(12'h73C, 32'h0000_0001);       // R9 critical gate core 3
      reg_write(12'h74C, 32'h0000_0001);       // R9 machine-check gate core 3
      src[479] = 1'b1; @(negedge clk);
      check_irq('0, 4'b1000, '0, "R8 critical line core 3 from bank 14");
      reg_read(12'h79C, 32'h0002_0000, "R10 critical summary bit 17");
      reg_write(12'h71C, 32'h0000_000F);
      check_irq('0, '0, 4'b1000, "R8 machine-check line core 3");
      reg_read(12'h7AC, 32'h0002_0000, "R10 machine-check summary");
      reg_write(12'h71C, 32'h0000_0003);
      check_irq('0, '0, '0, "R8 severity 00 disables source");
      reg_read(12'h700, 32'h0000_0001, "R8 source still pending while off");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule